// File: doc/BRIEF.md
# Counter/Timer with Clock Select

This block is the shared 16-bit counter/timer of a two-channel serial controller. A 3-bit select code picks both the operating mode and the clock that drives it. The clock can be an external input pin, either channel's 1X transmit clock, or the crystal clock, and some choices pass through a divide-by-16 prescaler. Every source is a slow signal that is sampled in the system clock domain. Each synchronized rising edge becomes one single-cycle enable pulse.

In event-counter mode a start command loads the 16-bit preload. The count then steps down once per enable pulse until it reaches zero. At zero it raises the ready flag and halts. In square-wave timer mode the count reloads from the preload each time it expires and the output level flips, so each half-period lasts the preload value in source ticks. The ready flag is raised on every low-to-high flip of that output. In both modes the flag falls only on a stop command, and the interrupt logic reads it from there.

Top module: `uart_ctr_timer`

## Requirements
- R1: While reset is asserted, and after reset is released, `ready` and `sq_out` are both 0.
- R2: Codes 3'b000, 3'b001 and 3'b010 select counter mode. Their clocks are `ext_in`, `txa_clk` and `txb_clk` respectively. Edges on the sources that are not selected have no effect on `ready` or `sq_out`.
- R3: The prescaled codes count one tick per 16 source rising edges. These are 3'b011 (counter mode, `xtal_clk`), 3'b101 (timer mode, `ext_in`) and 3'b111 (timer mode, `xtal_clk`). A start command clears the prescaler, so the first tick comes on the 16th edge after the start.
- R4: Codes 3'b100 and 3'b110 select timer mode clocked directly by `ext_in` and `xtal_clk` respectively.
- R5: In counter mode, a start command loads the preload, and each tick decrements the count. `ready` rises on the tick that brings the count to zero, which is after max(P,1) ticks for preload P. Counting then halts, and further ticks change nothing.
- R6: A start command drives `sq_out` low. In timer mode `sq_out` toggles every max(P,1) ticks, and the count reloads at each toggle. In counter mode `sq_out` never toggles.
- R7: In timer mode `ready` rises together with each low-to-high transition of `sq_out` and stays set afterwards.
- R8: `ready` is cleared only by `stop_cmd`, and a start command leaves it unchanged. A stop command also halts counting. When stop and start arrive in the same cycle, the stop wins and the start is ignored.
- R9: A source rising edge first sampled at clock edge k updates `ready` and `sq_out` at clock edge k+2.
- R10: A preload write does not disturb a count in progress. The new value is used at the next start or the next timer reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_in | input | 1 | External event/clock pin |
| txa_clk | input | 1 | Channel A transmit 1X clock |
| txb_clk | input | 1 | Channel B transmit 1X clock |
| xtal_clk | input | 1 | Crystal/external reference clock |
| src_sel | input | 3 | Mode and clock-source select code |
| preload_we | input | 1 | Write strobe for the preload register |
| preload_wdata | input | 16 | Preload value to write |
| start_cmd | input | 1 | Load the preload and start running |
| stop_cmd | input | 1 | Halt and clear the ready flag |
| ready | output | 1 | Terminal-count / rising-output flag for interrupts |
| sq_out | output | 1 | Square-wave timer output |

## Verification
A source edge appears at the outputs on the third clock edge after it is driven: two synchronizer stages, then the count register. The bench drives each source edge at a falling clock edge and holds it for two cycles. It then waits two more cycles, so every result has settled before it is sampled at a falling edge. One directed check samples at the exact cycle: `ready` is still 0 after the second edge and is 1 after the third. Command effects (start, stop, preload writes) appear one edge after the command, and the bench always checks them at least one full cycle later.

// File: rtl/ct_pkg.sv
package ct_pkg;
   typedef enum logic [2:0] {
      SRC_CNT_EXT    = 3'b000,
      SRC_CNT_TXA    = 3'b001,
      SRC_CNT_TXB    = 3'b010,
      SRC_CNT_XDIV   = 3'b011,
      SRC_TMR_EXT    = 3'b100,
      SRC_TMR_EXTDIV = 3'b101,
      SRC_TMR_XTAL   = 3'b110,
      SRC_TMR_XDIV   = 3'b111
   } ct_src_e;

   localparam int NUM_SRC = 4;
   localparam int IDX_EXT  = 0;
   localparam int IDX_TXA  = 1;
   localparam int IDX_TXB  = 2;
   localparam int IDX_XTAL = 3;

   function automatic logic is_timer(input logic [2:0] code);
      return code[2];
   endfunction
endpackage

// File: rtl/ct_sync.sv
// Synchronizes one slow source and emits a single-cycle pulse per rising edge.
module ct_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ct_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-1:0], d};
   end

   assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/ct_prescale.sv
// Divides an enable-pulse stream by DIV; cleared synchronously.
module ct_prescale #(
   parameter int DIV = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en_in,
   output logic en_out
);
   if (DIV < 1) begin : g_bad_div
      $error("ct_prescale: DIV must be positive");
   end

   if (DIV == 1) begin : g_pass
      assign en_out = en_in;
   end else begin : g_div
      localparam int PW = $clog2(DIV);
      logic [PW-1:0] cnt;
      logic          wrap;

      assign wrap   = (cnt == PW'(DIV - 1));
      assign en_out = en_in & wrap;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     cnt <= '0;
         else if (clr)   cnt <= '0;
         else if (en_in) cnt <= wrap ? '0 : cnt + 1'b1;
      end
   end
endmodule

// File: rtl/ct_core.sv
// Down counter with counter/timer behaviour, ready flag and square output.
module ct_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             timer_mode,
   input  logic [CNT_W-1:0] preload,
   input  logic             start_cmd,
   input  logic             stop_cmd,
   output logic             ready,
   output logic             sq_out
);
   logic [CNT_W-1:0] cnt;
   logic             run;
   logic             expire;

   assign expire = (cnt <= CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         run    <= 1'b0;
         ready  <= 1'b0;
         sq_out <= 1'b0;
      end else if (stop_cmd) begin
         run   <= 1'b0;
         ready <= 1'b0;
      end else if (start_cmd) begin
         run    <= 1'b1;
         cnt    <= preload;
         sq_out <= 1'b0;
      end else if (run && tick) begin
         if (!expire) begin
            cnt <= cnt - 1'b1;
         end else if (timer_mode) begin
            cnt    <= preload;
            sq_out <= ~sq_out;
            if (!sq_out) ready <= 1'b1;
         end else begin
            cnt   <= '0;
            run   <= 1'b0;
            ready <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/uart_ctr_timer.sv
module uart_ctr_timer
   import ct_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int PRESCALE    = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_in,
   input  logic             txa_clk,
   input  logic             txb_clk,
   input  logic             xtal_clk,
   input  logic [2:0]       src_sel,
   input  logic             preload_we,
   input  logic [CNT_W-1:0] preload_wdata,
   input  logic             start_cmd,
   input  logic             stop_cmd,
   output logic             ready,
   output logic             sq_out
);
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_w
      $error("uart_ctr_timer: CNT_W out of range");
   end
   if ((PRESCALE & (PRESCALE - 1)) != 0) begin : g_bad_pre
      $error("uart_ctr_timer: PRESCALE must be a power of two");
   end

   logic [NUM_SRC-1:0] raw_src;
   logic [NUM_SRC-1:0] edge_p;
   logic               ext_div, xtal_div;
   logic               tick;
   logic [CNT_W-1:0]   preload_q;

   assign raw_src[IDX_EXT]  = ext_in;
   assign raw_src[IDX_TXA]  = txa_clk;
   assign raw_src[IDX_TXB]  = txb_clk;
   assign raw_src[IDX_XTAL] = xtal_clk;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_sync
      ct_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (raw_src[i]),
         .rise  (edge_p[i])
      );
   end

   ct_prescale #(.DIV(PRESCALE)) u_pre_ext (
      .clk(clk), .rst_n(rst_n), .clr(start_cmd),
      .en_in(edge_p[IDX_EXT]), .en_out(ext_div)
   );

   ct_prescale #(.DIV(PRESCALE)) u_pre_xtal (
      .clk(clk), .rst_n(rst_n), .clr(start_cmd),
      .en_in(edge_p[IDX_XTAL]), .en_out(xtal_div)
   );

   always_comb begin
      case (ct_src_e'(src_sel))
         SRC_CNT_EXT:    tick = edge_p[IDX_EXT];
         SRC_CNT_TXA:    tick = edge_p[IDX_TXA];
         SRC_CNT_TXB:    tick = edge_p[IDX_TXB];
         SRC_CNT_XDIV:   tick = xtal_div;
         SRC_TMR_EXT:    tick = edge_p[IDX_EXT];
         SRC_TMR_EXTDIV: tick = ext_div;
         SRC_TMR_XTAL:   tick = edge_p[IDX_XTAL];
         SRC_TMR_XDIV:   tick = xtal_div;
         default:        tick = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          preload_q <= '0;
      else if (preload_we) preload_q <= preload_wdata;
   end

   ct_core #(.CNT_W(CNT_W)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .timer_mode (is_timer(src_sel)),
      .preload    (preload_q),
      .start_cmd  (start_cmd),
      .stop_cmd   (stop_cmd),
      .ready      (ready),
      .sq_out     (sq_out)
   );
endmodule

// File: rtl/uart_ctr_timer_chk.sv
module uart_ctr_timer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] src_sel,
   input logic       start_cmd,
   input logic       stop_cmd,
   input logic       ready,
   input logic       sq_out
);
   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (!ready && !sq_out));

   // R8
   ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready) |-> $past(stop_cmd));

   // R8
   stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_cmd |=> !ready);

   // R7
   timer_ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ready) && $past(src_sel[2])) |-> $rose(sq_out));

   // R6
   sq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sq_out != $past(sq_out)) |-> ($past(src_sel[2]) || $past(start_cmd)));

   // R5
   counter_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ready) && !$past(src_sel[2])) |-> $stable(sq_out));
endmodule

bind uart_ctr_timer uart_ctr_timer_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_sel   (src_sel),
   .start_cmd (start_cmd),
   .stop_cmd  (stop_cmd),
   .ready     (ready),
   .sq_out    (sq_out)
);

// File: tb/sim_uart_ctr_timer.sv
`timescale 1ns/1ps
module sim_uart_ctr_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  srcs = 4'b0;
   logic [2:0]  src_sel = 3'b000;
   logic        preload_we = 1'b0;
   logic [15:0] preload_wdata = 16'd0;
   logic        start_cmd = 1'b0;
   logic        stop_cmd = 1'b0;
   logic        ready, sq_out;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   uart_ctr_timer u0 (
      .clk(clk), .rst_n(rst_n),
      .ext_in(srcs[0]), .txa_clk(srcs[1]), .txb_clk(srcs[2]), .xtal_clk(srcs[3]),
      .src_sel(src_sel), .preload_we(preload_we), .preload_wdata(preload_wdata),
      .start_cmd(start_cmd), .stop_cmd(stop_cmd),
      .ready(ready), .sq_out(sq_out)
   );

   task automatic chk(input string req, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0b expected %0b", req, got, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bump(input int idx, input int n);
      for (int i = 0; i < n; i++) begin
         srcs[idx] = 1'b1; cyc(2);
         srcs[idx] = 1'b0; cyc(2);
      end
   endtask

   task automatic cmd(input bit st, input bit sp);
      start_cmd = st; stop_cmd = sp; cyc(1);
      start_cmd = 1'b0; stop_cmd = 1'b0; cyc(1);
   endtask

   task automatic wr(input logic [15:0] v);
      preload_wdata = v; preload_we = 1'b1; cyc(1);
      preload_we = 1'b0; cyc(1);
   endtask

   function automatic int src_of(input int code);
      case (code)
         1: return 1;
         2: return 2;
         3, 6, 7: return 3;
         default: return 0;
      endcase
   endfunction

   function automatic int ticks_of(input int code, input int edges);
      return (code == 3 || code == 5 || code == 7) ? edges / 16 : edges;
   endfunction

   function automatic logic [1:0] model(input int code, input int p, input int t);
      int pe = (p == 0) ? 1 : p;
      int tg;
      if (code < 4) return {logic'(t >= pe), 1'b0};
      tg = t / pe;
      return {logic'(tg >= 1), logic'(tg % 2)};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [1:0] e;
      void'($urandom(32'd4242));
      cyc(3);
      chk("R1 ready in reset", ready, 1'b0);
      chk("R1 sq in reset", sq_out, 1'b0);
      rst_n = 1'b1; cyc(2);
      chk("R1 ready after reset", ready, 1'b0);

      // R9 exact latency
      src_sel = 3'b000; wr(16'd1); cmd(1, 0);
      srcs[0] = 1'b1;
      @(posedge clk); @(posedge clk); #1;
      chk("R9 ready not yet after two edges", ready, 1'b0);
      @(posedge clk); #1;
      chk("R9 ready after third edge", ready, 1'b1);
      @(negedge clk); srcs[0] = 1'b0; cyc(3);

      // R2 unselected sources ignored, R5 terminal count
      cmd(0, 1);
      src_sel = 3'b001; wr(16'd2); cmd(1, 0);
      bump(2, 3); bump(0, 3); bump(3, 3); cyc(2);
      chk("R2 unselected sources ignored", ready, 1'b0);
      bump(1, 1); cyc(2);
      chk("R5 one tick short of terminal", ready, 1'b0);
      bump(1, 1); cyc(2);
      chk("R5 ready at terminal count", ready, 1'b1);
      bump(1, 5); cyc(2);
      chk("R5 halted after terminal", ready, 1'b1);
      chk("R6 no toggle in counter mode", sq_out, 1'b0);
      src_sel = 3'b010; cmd(0, 1); cmd(1, 0);
      bump(2, 2); cyc(2);
      chk("R2 txb counter code 010", ready, 1'b1);

      // R8 start keeps ready; stop clears; stop wins
      cmd(1, 0); cyc(2);
      chk("R8 start does not clear ready", ready, 1'b1);
      cmd(0, 1);
      chk("R8 stop clears ready", ready, 1'b0);
      src_sel = 3'b000; wr(16'd1); cmd(1, 1);
      bump(0, 3); cyc(2);
      chk("R8 stop wins over start", ready, 1'b0);

      // R3 prescaled counter
      src_sel = 3'b011; wr(16'd1); cmd(1, 0);
      bump(3, 15); cyc(2);
      chk("R3 fifteen xtal edges no tick", ready, 1'b0);
      bump(3, 1); cyc(2);
      chk("R3 sixteenth xtal edge ticks", ready, 1'b1);

      // R4 R6 R7 timer on ext
      cmd(0, 1);
      src_sel = 3'b100; wr(16'd3); cmd(1, 0);
      bump(0, 2); cyc(2);
      chk("R6 sq low before half period", sq_out, 1'b0);
      chk("R7 no ready before rise", ready, 1'b0);
      bump(0, 1); cyc(2);
      chk("R4 R6 sq high after half period", sq_out, 1'b1);
      chk("R7 ready on sq rise", ready, 1'b1);
      bump(0, 3); cyc(2);
      chk("R6 sq low after second half", sq_out, 1'b0);
      chk("R7 ready stays set", ready, 1'b1);

      // R10 preload change mid-run, timer on xtal
      cmd(0, 1);
      src_sel = 3'b110; wr(16'd2); cmd(1, 0);
      wr(16'd5);
      bump(3, 2); cyc(2);
      chk("R10 old preload used for current count", sq_out, 1'b1);
      bump(3, 4); cyc(2);
      chk("R10 new preload after reload", sq_out, 1'b1);
      bump(3, 1); cyc(2);
      chk("R10 toggle after new preload", sq_out, 1'b0);

      // constrained random, all codes
      for (int it = 0; it < 24; it++) begin
         int code = int'($urandom % 8);
         int p    = int'($urandom % 12);
         int pe   = (p == 0) ? 1 : p;
         int n;
         bit dv   = (code == 3 || code == 5 || code == 7);
         n = dv ? int'($urandom % (16 * (2 * pe + 3))) : int'($urandom % (3 * pe + 4));
         cmd(0, 1);
         src_sel = code[2:0]; wr(p[15:0]); cmd(1, 0);
         bump(src_of(code), n); cyc(2);
         e = model(code, p, ticks_of(code, n));
         // R2 R3 R4 R5 R6 R7 under random codes
         chk($sformatf("R5 R7 random ready code %0d p %0d n %0d", code, p, n), ready, e[1]);
         chk($sformatf("R6 random sq code %0d p %0d n %0d", code, p, n), sq_out, e[0]);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule